// File: doc/BRIEF.md
# Per-Phase Resonant Voltage Regulator

This block is the discrete-time voltage loop for one output phase of a three-phase, four-wire inverter. A sampling strobe arrives once per sample period (20 kHz in the target system). The block then takes a signed voltage reference, the measured filter-capacitor voltage and the measured capacitor current. It produces one signed phase-voltage command for the modulator. The command is the sum of four parts: the reference passed straight through as feedforward, a proportional term on the voltage error, a bank of resonant sections, and a damping term that subtracts a gain times the capacitor current.

There are seven resonant sections. Each is a second-order recursive filter. The coefficients are computed off-chip for the fundamental (50 Hz) and the odd harmonics 3 through 13, with phase advance and damping already included in them. The coefficients are written through a simple register port, and every section has its own enable. One shared multiplier evaluates all terms one after another, so the result appears a fixed number of clock cycles after each strobe, far inside one sample period. Three instances serve the three phases, and each one sees only its own phase error.

Top module: `resonant_vreg`

## Requirements
- R1: After reset, `v_out` is 0 and `v_valid` is 0. All coefficients, both gains, all section enables and all filter histories are 0, so the first result equals the reference alone.
- R2: Q-format values carry FRAC = 14 fraction bits. The result is formed in this order: add each enabled section output shifted left by FRAC, in ascending section order; add Kp·e; subtract Kad·i_cap; add v_ref shifted left by FRAC. The total is then arithmetically shifted right by FRAC, which rounds toward minus infinity.
- R3: The error e is v_ref − v_meas, saturated to the 16-bit signed range −32768..32767 before any use.
- R4: A section computes y = b0·e[n] + b1·e[n−1] + b2·e[n−2] − a1·y[n−1] − a2·y[n−2], accumulated in that order. The sum is shifted right by FRAC (floor) and saturated to 16 bits. The error history is shared by all sections, and the output history belongs to each section.
- R5: A disabled section adds nothing to the result. Its output history is forced to zero on every sample it is disabled, so after it is re-enabled it starts from a zero state. The other sections are not affected.
- R6: A strobe is accepted only when no computation is running. `v_valid` pulses high for exactly one cycle, and it is observed on the 5·NSEC+3 = 38th rising edge after the edge that accepted the strobe.
- R7: A strobe that arrives while a computation is running is ignored. It produces no extra pulse and changes neither the timing nor the value of the running result.
- R8: The result is clipped to the range −VLIM..+VLIM, where VLIM defaults to 28000 and is the scaled half of the DC bus voltage.
- R9: `v_out` keeps its value between `v_valid` pulses.
- R10: For writes with `cfg_we` high, address bits [5:3] select the section and bits [2:0] select the slot. Slots 0..4 hold b0, b1, b2, a1, a2, and slot 5 bit 0 is the section enable. Section number 7 (address 56 is Kp, address 57 is Kad) holds the gains.
- R11: Every addition in a section accumulator and in the output total saturates to the 32-bit signed range at each step, in the order given in R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe |
| v_ref | input | 16 | Signed voltage reference |
| v_meas | input | 16 | Signed measured capacitor voltage |
| i_cap | input | 16 | Signed measured capacitor current |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration address |
| cfg_data | input | 16 | Signed configuration data |
| v_out | output | 16 | Signed clipped phase-voltage command |
| v_valid | output | 1 | One-cycle result strobe |

## Verification
The test first runs gains only with every section off, to separate the proportional, damping and feedforward paths and to show floor rounding on negative values. A single section driven by a waveform then exercises the recurrence and its history. Seven sections with pseudo-random coefficients and inputs check ordering and the shared error history. Extreme inputs separate error saturation, output clipping and per-step accumulator saturation from a single saturation at the end. A strobe sent during a computation shows whether it is ignored or restarts the work. Disabling one section for a single sample shows whether its history is cleared or held.

// File: rtl/resonant_vreg.sv
module resonant_vreg #(
  parameter int NSEC = 7,
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int FRAC = 14,
  parameter int VLIM = 28000,
  parameter int ADDR_W = $clog2(8 * (NSEC + 1))
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic signed [DW-1:0] v_ref,
  input  logic signed [DW-1:0] v_meas,
  input  logic signed [DW-1:0] i_cap,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic signed [DW-1:0] cfg_data,
  output logic signed [DW-1:0] v_out,
  output logic                 v_valid
);
  localparam int SEC_W = $clog2(NSEC + 1);
  localparam int SI_W = $clog2(NSEC);
  localparam int NCOEF = 5 * NSEC;
  localparam int CI_W = $clog2(NCOEF);
  localparam int SA_W = ADDR_W - 3;
  localparam logic signed [AW+1:0] AMAX = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [AW+1:0] AMIN = {3'b111, {(AW-1){1'b0}}};
  localparam logic signed [AW-1:0] DMAX = AW'(2 ** (DW - 1) - 1);
  localparam logic signed [AW-1:0] DMIN = -DMAX - AW'(1);
  localparam logic signed [AW-1:0] VHI = AW'(VLIM);
  localparam logic signed [AW-1:0] VLO = -VHI;

  function automatic logic signed [AW-1:0] sat_acc(input logic signed [AW+1:0] x);
    if (x > AMAX) return AMAX[AW-1:0];
    if (x < AMIN) return AMIN[AW-1:0];
    return x[AW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [AW-1:0] x);
    if (x > DMAX) return DMAX[DW-1:0];
    if (x < DMIN) return DMIN[DW-1:0];
    return x[DW-1:0];
  endfunction

  logic signed [DW-1:0] coef [NCOEF];
  logic signed [DW-1:0] y1 [NSEC];
  logic signed [DW-1:0] y2 [NSEC];
  logic [NSEC-1:0]      en;
  logic signed [DW-1:0] kp, kad, e0, e1, e2, ref_q, ic_q;
  logic                 busy;
  logic [SEC_W-1:0]     sec_q;
  logic [2:0]           k_q;
  logic signed [AW-1:0] sacc, total;

  logic                 in_sec, sub;
  logic [SI_W-1:0]      sidx;
  logic [CI_W-1:0]      ci;
  logic signed [DW-1:0] opa, opb, y_n, out_n;
  logic signed [AW-1:0] prod, sacc_n, total_n, res;
  logic signed [AW+1:0] pe, t_add;
  logic signed [DW:0]   ediff;
  logic [SA_W-1:0]      wsec;
  logic [2:0]           wslot;

  assign in_sec = sec_q < SEC_W'(NSEC);
  assign sidx   = in_sec ? SI_W'(sec_q) : '0;
  assign ci     = CI_W'(int'(sidx) * 5 + int'(k_q));
  assign ediff  = (DW+1)'(v_ref) - (DW+1)'(v_meas);
  assign wsec   = cfg_addr[ADDR_W-1:3];
  assign wslot  = cfg_addr[2:0];

  always_comb begin
    opa = '0;
    opb = '0;
    sub = 1'b0;
    if (in_sec) begin
      opa = coef[ci];
      sub = (k_q >= 3'd3);
      case (k_q)
        3'd0:    opb = e0;
        3'd1:    opb = e1;
        3'd2:    opb = e2;
        3'd3:    opb = y1[sidx];
        default: opb = y2[sidx];
      endcase
    end else begin
      opa = (k_q == 3'd0) ? kp : kad;
      opb = (k_q == 3'd0) ? e0 : ic_q;
      sub = (k_q == 3'd1);
    end
  end

  assign prod   = AW'(opa) * AW'(opb);
  assign pe     = (AW+2)'(prod);
  assign sacc_n = sat_acc((k_q == 3'd0) ? pe : (AW+2)'(sacc) + (sub ? -pe : pe));
  assign y_n    = sat_dw(sacc_n >>> FRAC);

  always_comb begin
    t_add = '0;
    if (in_sec) begin
      if (k_q == 3'd4 && en[sidx]) t_add = (AW+2)'(y_n) <<< FRAC;
    end else begin
      case (k_q)
        3'd0:    t_add = pe;
        3'd1:    t_add = -pe;
        default: t_add = (AW+2)'(ref_q) <<< FRAC;
      endcase
    end
  end

  assign total_n = sat_acc((AW+2)'(total) + t_add);
  assign res     = total_n >>> FRAC;
  assign out_n   = (res > VHI) ? VHI[DW-1:0] : (res < VLO) ? VLO[DW-1:0] : res[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) coef[i] <= '0;
      for (int i = 0; i < NSEC; i++) begin
        y1[i] <= '0;
        y2[i] <= '0;
      end
      en <= '0;
      kp <= '0;
      kad <= '0;
      e0 <= '0;
      e1 <= '0;
      e2 <= '0;
      ref_q <= '0;
      ic_q <= '0;
      busy <= 1'b0;
      sec_q <= '0;
      k_q <= '0;
      sacc <= '0;
      total <= '0;
      v_out <= '0;
      v_valid <= 1'b0;
    end else begin
      v_valid <= 1'b0;
      if (cfg_we) begin
        if (int'(wsec) < NSEC) begin
          if (wslot < 3'd5) coef[CI_W'(int'(wsec) * 5 + int'(wslot))] <= cfg_data;
          else if (wslot == 3'd5) en[SI_W'(wsec)] <= cfg_data[0];
        end else if (int'(wsec) == NSEC) begin
          if (wslot == 3'd0) kp <= cfg_data;
          if (wslot == 3'd1) kad <= cfg_data;
        end
      end
      if (!busy) begin
        if (tick) begin
          ref_q <= v_ref;
          ic_q <= i_cap;
          e0 <= sat_dw(AW'(ediff));
          busy <= 1'b1;
          sec_q <= '0;
          k_q <= '0;
          total <= '0;
        end
      end else begin
        sacc <= sacc_n;
        total <= total_n;
        if (in_sec) begin
          if (k_q == 3'd4) begin
            if (en[sidx]) begin
              y2[sidx] <= y1[sidx];
              y1[sidx] <= y_n;
            end else begin
              y2[sidx] <= '0;
              y1[sidx] <= '0;
            end
            k_q <= '0;
            sec_q <= sec_q + SEC_W'(1);
          end else begin
            k_q <= k_q + 3'd1;
          end
        end else if (k_q == 3'd2) begin
          e2 <= e1;
          e1 <= e0;
          v_out <= out_n;
          v_valid <= 1'b1;
          busy <= 1'b0;
        end else begin
          k_q <= k_q + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/resonant_vreg_chk.sv
module resonant_vreg_chk #(
  parameter int NSEC = 7,
  parameter int DW = 16,
  parameter int VLIM = 28000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 v_valid,
  input logic signed [DW-1:0] v_out
);
  localparam int LAT = 5 * NSEC + 3;

  logic ck_busy;
  int   ck_cnt;
  logic ck_done;

  assign ck_done = ck_busy && (ck_cnt == LAT + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_busy <= 1'b0;
      ck_cnt <= 0;
    end else if (tick && (!ck_busy || ck_done)) begin
      ck_busy <= 1'b1;
      ck_cnt <= 1;
    end else if (ck_done) begin
      ck_busy <= 1'b0;
    end else if (ck_busy) begin
      ck_cnt <= ck_cnt + 1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (!v_valid && v_out == '0));
  p_valid_on_time_r6: assert property (@(posedge clk) disable iff (!rst_n) v_valid |-> ck_done);
  p_result_due_r7: assert property (@(posedge clk) disable iff (!rst_n) ck_done |-> v_valid);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) v_valid |=> !v_valid);
  p_out_clipped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> (int'(v_out) <= VLIM && int'(v_out) >= -VLIM));
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n) !v_valid |-> $stable(v_out));
endmodule

bind resonant_vreg resonant_vreg_chk #(.NSEC(NSEC), .DW(DW), .VLIM(VLIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .v_valid(v_valid), .v_out(v_out)
);

// File: tb/resonant_vreg_tb.sv
module resonant_vreg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEC = 7;
  localparam int FRAC = 14;
  localparam int VLIM = 28000;
  localparam int LAT = 5 * NSEC + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic signed [15:0] v_ref = '0, v_meas = '0, i_cap = '0, cfg_data = '0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic signed [15:0] v_out;
  logic v_valid;

  resonant_vreg u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .v_ref(v_ref), .v_meas(v_meas), .i_cap(i_cap),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .v_out(v_out), .v_valid(v_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint mc [5*NSEC];
  bit     men [NSEC];
  longint my1 [NSEC];
  longint my2 [NSEC];
  longint mkp = 0, mkad = 0, me1 = 0, me2 = 0;
  int n_chk = 0, n_fail = 0;
  string req = "R1";
  bit pend = 0, run_chk = 0, done = 0;
  longint due = 0, exp_out = 0, last_out = 0;
  int unsigned lcg = 32'd12345;

  function automatic longint sat(longint x, longint lo, longint hi);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  function automatic longint sa(longint x);
    longint big = longint'(1) <<< 31;
    return sat(x, -big, big - 1);
  endfunction

  function automatic longint s16(longint x);
    return sat(x, -32768, 32767);
  endfunction

  // Reference model of R2, R3, R4, R5, R8, R11
  function automatic longint model_step(longint r, longint m, longint ic);
    longint e = s16(r - m);
    longint tot = 0;
    for (int s = 0; s < NSEC; s++) begin
      if (men[s]) begin
        longint acc = mc[s*5] * e;
        longint y;
        acc = sa(acc + mc[s*5+1] * me1);
        acc = sa(acc + mc[s*5+2] * me2);
        acc = sa(acc - mc[s*5+3] * my1[s]);
        acc = sa(acc - mc[s*5+4] * my2[s]);
        y = s16(acc >>> FRAC);
        tot = sa(tot + (y <<< FRAC));
        my2[s] = my1[s];
        my1[s] = y;
      end else begin
        my1[s] = 0;
        my2[s] = 0;
      end
    end
    tot = sa(tot + mkp * e);
    tot = sa(tot - mkad * ic);
    tot = sa(tot + (r <<< FRAC));
    me2 = me1;
    me1 = e;
    return sat(tot >>> FRAC, -VLIM, VLIM);
  endfunction

  task automatic chk(bit ok, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Every-clock comparison: R6 timing of the strobe, R9 hold between strobes
  always @(negedge clk) begin
    if (run_chk) begin
      if (pend && cyc == due) begin
        chk(v_valid == 1'b1, "R6 valid strobe", longint'(v_valid), 1);
        chk(longint'(v_out) == exp_out, "result", longint'(v_out), exp_out);
        last_out = exp_out;
        pend = 0;
      end else begin
        chk(v_valid == 1'b0, "R6 no strobe", longint'(v_valid), 0);
        chk(longint'(v_out) == last_out, "R9 hold", longint'(v_out), last_out);
      end
    end
  end

  // R10 address map: section*8 + slot, gains at section NSEC
  task automatic cfg(int addr, longint d);
    logic signed [15:0] d16 = 16'(d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 6'(addr);
    cfg_data = d16;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr / 8 < NSEC) begin
      if (addr % 8 < 5) mc[(addr / 8) * 5 + addr % 8] = longint'(d16);
      else if (addr % 8 == 5) men[addr / 8] = d16[0];
    end else if (addr / 8 == NSEC) begin
      if (addr % 8 == 0) mkp = longint'(d16);
      if (addr % 8 == 1) mkad = longint'(d16);
    end
  endtask

  task automatic set_sec(int s, longint b0, longint b1, longint b2, longint a1, longint a2, bit e);
    cfg(s * 8 + 0, b0);
    cfg(s * 8 + 1, b1);
    cfg(s * 8 + 2, b2);
    cfg(s * 8 + 3, a1);
    cfg(s * 8 + 4, a2);
    cfg(s * 8 + 5, longint'(e));
  endtask

  task automatic sample(longint r, longint m, longint ic, bit glitch);
    @(negedge clk);
    v_ref = 16'(r);
    v_meas = 16'(m);
    i_cap = 16'(ic);
    tick = 1'b1;
    exp_out = model_step(r, m, ic);
    due = cyc + 1 + LAT;
    pend = 1;
    @(negedge clk);
    tick = 1'b0;
    if (glitch) begin
      // R7: strobe with other inputs in the middle of the computation
      repeat (10) @(negedge clk);
      v_ref = 16'sd9999;
      v_meas = -16'sd9999;
      i_cap = 16'sd1234;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (LAT - 10) @(negedge clk);
    end else begin
      repeat (LAT + 1) @(negedge clk);
    end
  endtask

  function automatic longint rnd(int sh);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return longint'($signed(lcg[31:16])) >>> sh;
  endfunction

  initial begin
    for (int i = 0; i < 5 * NSEC; i++) mc[i] = 0;
    for (int i = 0; i < NSEC; i++) begin
      men[i] = 0;
      my1[i] = 0;
      my2[i] = 0;
    end
    repeat (3) @(negedge clk);
    req = "R1";
    chk(v_out == '0, "reset v_out", longint'(v_out), 0);
    chk(v_valid == 1'b0, "reset v_valid", longint'(v_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(v_out == '0 && v_valid == 1'b0, "after reset", longint'(v_out), 0);
    last_out = 0;
    run_chk = 1;
    // R1: nothing configured, result equals the reference
    sample(100, 50, 10, 0);
    sample(-321, 400, -77, 0);

    // R2, R10: gains only, floor rounding on negative values
    req = "R2";
    cfg(NSEC * 8 + 0, 8192);
    cfg(NSEC * 8 + 1, 4096);
    sample(1000, 900, 300, 0);
    sample(-1000, -997, 5, 0);
    sample(0, 3, -3, 0);
    sample(5000, 6001, 1111, 0);

    // R3: error saturation in both directions
    req = "R3";
    cfg(NSEC * 8 + 1, 0);
    sample(1000, -32768, 0, 0);
    sample(-1000, 32767, 0, 0);

    // R8: clipping of the output
    req = "R8";
    cfg(NSEC * 8 + 0, 32767);
    sample(20000, 0, 0, 0);
    sample(-20000, 0, 0, 0);
    cfg(NSEC * 8 + 0, 0);

    // R4: one resonator on section 2 driven by a periodic waveform
    req = "R4";
    set_sec(2, 3000, -2000, 500, -32000, 16000, 1);
    for (int n = 0; n < 16; n++) begin
      longint w = (n % 8 < 4) ? (n % 4) * 900 : -(n % 4) * 900;
      sample(w, w / 3, w / 7, 0);
    end

    // R2, R4: all sections with pseudo-random coefficients and inputs
    req = "R2";
    for (int s = 0; s < NSEC; s++) set_sec(s, rnd(2), rnd(2), rnd(2), rnd(1), rnd(2), 1);
    cfg(NSEC * 8 + 0, 3000);
    cfg(NSEC * 8 + 1, 2000);
    for (int n = 0; n < 20; n++) sample(rnd(1), rnd(1), rnd(2), 0);

    // R5: section 3 disabled for one sample, then re-enabled from zero state
    req = "R5";
    cfg(3 * 8 + 5, 0);
    sample(rnd(1), rnd(1), rnd(2), 0);
    cfg(3 * 8 + 5, 1);
    for (int n = 0; n < 6; n++) sample(rnd(1), rnd(1), rnd(2), 0);

    // R7: a strobe during the computation is ignored
    req = "R7";
    sample(1500, 200, 40, 1);
    sample(-800, 100, -20, 1);
    sample(300, 300, 0, 0);

    // R11: per-step accumulator saturation in the stated order
    req = "R11";
    for (int s = 0; s < NSEC; s++) cfg(s * 8 + 5, 0);
    cfg(NSEC * 8 + 0, 0);
    cfg(NSEC * 8 + 1, 0);
    sample(0, 0, 0, 0);
    sample(0, 0, 0, 0);
    set_sec(0, 32767, 32767, 32767, 32767, 32767, 1);
    sample(0, -32768, 0, 0);
    sample(0, -32768, 0, 0);
    sample(0, -32768, 0, 0);
    chk(last_out == 7 && v_out == 16'sd7, "saturating sum", longint'(v_out), 7);
    sample(0, -32768, 0, 0);

    run_chk = 0;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule